// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This block is a memory-mapped real-time clock on a 32-bit APB-style register bus. A free-running prescaler divides the bus clock down to a one-cycle tick once per second. Each tick advances a 32-bit seconds counter. Software can overwrite the counter through a load register. It can also program a match value.

When a tick moves the counter onto the match value, a sticky raw interrupt flag is set. A one-bit mask passes that flag to a level-high interrupt pin. The flag stays set until software writes a one to the clear register.

The block also returns a fixed control value and byte-wide identification words, so that drivers can probe it. Every access completes in a single cycle with no wait states.

Top module: `secs_rtc`

## Requirements
- R1: After synchronous reset the counter, match, load, mask and raw flag all read 0, and `irq` is low.
- R2: A write to offset 0x008 (load) stores the value there and sets the counter to it from the next cycle on. If a tick falls in the same cycle, the load wins.
- R3: Without a load, the counter (offset 0x000) increases by exactly one on each prescaler tick. Ticks come every CLK_HZ bus cycles, and the count wraps modulo 2^32.
- R4: A tick that moves the counter onto the match value (offset 0x004, compared against the match value held before the tick) sets the raw flag. The raw flag reads as bit 0 of offset 0x014 and stays set until it is cleared.
- R5: Loading the counter with the match value does not set the raw flag. Writing a match value equal to the current count does not set it either. The next event comes only when a tick advances into the value, which after an equal load means a full wrap.
- R6: Writing offset 0x010 (mask) stores only bit 0 of the write data. Offset 0x018 reads the raw flag ANDed with the mask.
- R7: A write to offset 0x01C with data bit 0 set clears the raw flag. Bit 0 clear leaves the flag unchanged. A match event in the same cycle as a clear leaves the flag set.
- R8: `irq` equals the raw flag ANDed with the mask at all times.
- R9: Offset 0x00C reads 1.
- R10: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read the bytes 0x31, 0x10, 0x14, 0x00. Offsets 0xFF0 through 0xFFC read 0x0D, 0xF0, 0x05, 0xB1. Each byte sits in bits 7:0, with the upper bits zero.
- R11: These reads return 0: unassigned offsets, offset 0x01C, and any address with bits 1:0 nonzero. Writes to 0x000, 0x00C, 0x014, 0x018, the ID offsets and unassigned offsets change no state.
- R12: `pready` is always 1 and `pslverr` always 0. A write takes effect at the clock edge of its access phase, and read data is valid during the access phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the timebase for the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1, so there are no wait states |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with CLK_HZ set to 5, so that a simulated second lasts five bus cycles. This lets dozens of counter advances and matches occur within a few hundred cycles. With it the bench can place a load with the match value, an equal-value match write, and a wrap from 0xFFFFFFFE through zero, and then observe whether the flag is set. A behavioural model runs beside the block and is compared on every cycle. It also catches any collision of ticks with loads or clears that the directed sequence happens to produce.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;

    localparam int ADDR_W = 12;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int CNT_W  = 32;

    // word indices (byte offset >> 2)
    localparam logic [IDX_W-1:0] IDX_COUNT = 10'h000;
    localparam logic [IDX_W-1:0] IDX_MATCH = 10'h001;
    localparam logic [IDX_W-1:0] IDX_LOAD  = 10'h002;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 10'h003;
    localparam logic [IDX_W-1:0] IDX_MASK  = 10'h004;
    localparam logic [IDX_W-1:0] IDX_RAW   = 10'h005;
    localparam logic [IDX_W-1:0] IDX_MSK_ST = 10'h006;
    localparam logic [IDX_W-1:0] IDX_CLR   = 10'h007;
    localparam logic [IDX_W-3:0] GRP_PERIPH = 8'hFE;
    localparam logic [IDX_W-3:0] GRP_CELL   = 8'hFF;

    localparam logic [31:0] PERIPH_WORD = 32'h0014_1031;
    localparam logic [31:0] CELL_WORD   = 32'hB105_F00D;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_MATCH,
        WR_LOAD,
        WR_MASK,
        WR_CLR
    } wr_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] match;
        logic [CNT_W-1:0] load;
    } time_regs_t;

    function automatic wr_kind_e classify(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_MATCH: return WR_MATCH;
            IDX_LOAD:  return WR_LOAD;
            IDX_MASK:  return WR_MASK;
            IDX_CLR:   return WR_CLR;
            default:   return WR_NONE;
        endcase
    endfunction

    function automatic logic [31:0] id_byte(input logic [31:0] word, input logic [1:0] n);
        return {24'h0, word[8*n +: 8]};
    endfunction

endpackage

// File: rtl/secs_rtc_prescale.sv
module secs_rtc_prescale #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst)       cnt <= '0;
                else if (tick) cnt <= '0;
                else           cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == LAST);

            // R3
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter
    import secs_rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_we,
    input  logic             match_we,
    input  logic [CNT_W-1:0] wdata,
    output time_regs_t       regs,
    output logic             match_evt
);
    time_regs_t r;
    logic [CNT_W-1:0] next_cnt;

    assign next_cnt  = r.count + 1'b1;
    // event only on an advance, never on a load
    assign match_evt = tick && !load_we && (next_cnt == r.match);

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else begin
            if (load_we) begin
                r.load  <= wdata;
                r.count <= wdata;
            end else if (tick) begin
                r.count <= next_cnt;
            end
            if (match_we) r.match <= wdata;
        end
    end

    assign regs = r;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load_we |=> (regs.count == $past(wdata) && regs.load == $past(wdata)));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_we) |=> regs.count == $past(regs.count) + 32'd1);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_we) |=> $stable(regs.count));
endmodule

// File: rtl/secs_rtc_irq.sv
module secs_rtc_irq (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic mask_we,
    input  logic clr_we,
    input  logic wbit,
    output logic raw,
    output logic mask,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= 1'b0;
            mask <= 1'b0;
        end else begin
            if (evt)                 raw <= 1'b1;
            else if (clr_we && wbit) raw <= 1'b0;
            if (mask_we) mask <= wbit;
        end
    end

    assign irq = raw & mask;

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (raw && !(clr_we && wbit)) |=> raw);
    // R4
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> raw);
    // R6
    mask_bit_chk: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> mask == $past(wbit));
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && wbit && !evt) |=> !raw);
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import secs_rtc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);
    logic             aligned;
    logic [IDX_W-1:0] idx;
    wr_kind_e         wkind;
    logic             tick;
    logic             match_evt;
    logic             raw;
    logic             mask;
    time_regs_t       regs;

    assign aligned = (paddr[1:0] == 2'b00);
    assign idx     = paddr[ADDR_W-1:2];

    always_comb begin
        if (psel && penable && pwrite && aligned) wkind = classify(idx);
        else                                      wkind = WR_NONE;
    end

    secs_rtc_prescale #(.DIV(CLK_HZ)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    secs_rtc_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_we   (wkind == WR_LOAD),
        .match_we  (wkind == WR_MATCH),
        .wdata     (pwdata),
        .regs      (regs),
        .match_evt (match_evt)
    );

    secs_rtc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (match_evt),
        .mask_we (wkind == WR_MASK),
        .clr_we  (wkind == WR_CLR),
        .wbit    (pwdata[0]),
        .raw     (raw),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        prdata = '0;
        if (aligned) begin
            case (idx)
                IDX_COUNT:  prdata = regs.count;
                IDX_MATCH:  prdata = regs.match;
                IDX_LOAD:   prdata = regs.load;
                IDX_CTRL:   prdata = 32'd1;
                IDX_MASK:   prdata = {31'd0, mask};
                IDX_RAW:    prdata = {31'd0, raw};
                IDX_MSK_ST: prdata = {31'd0, raw & mask};
                default: begin
                    if (idx[IDX_W-1:2] == GRP_PERIPH)
                        prdata = id_byte(PERIPH_WORD, idx[1:0]);
                    else if (idx[IDX_W-1:2] == GRP_CELL)
                        prdata = id_byte(CELL_WORD, idx[1:0]);
                end
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // R5
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wkind == WR_LOAD && !raw) |=> !raw);
    // R11
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && aligned && idx == IDX_COUNT && !tick) |=> $stable(regs.count));
endmodule

// File: tb/sim_secs_rtc.sv
module sim_secs_rtc;
    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int          m_presc = 0;
    logic [31:0] m_count = 0, m_match = 0, m_load = 0;
    logic        m_mask = 0, m_raw = 0;

    always #2.5 clk = ~clk;

    secs_rtc #(.CLK_HZ(DIV)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int w;
        if (a[1:0] != 2'b00) return 32'd0;
        w = int'(a >> 2);
        case (w)
            0: return m_count;
            1: return m_match;
            2: return m_load;
            3: return 32'd1;
            4: return {31'd0, m_mask};
            5: return {31'd0, m_raw};
            6: return {31'd0, m_raw & m_mask};
            default: begin
                if (w >= 'h3F8 && w <= 'h3FB) return (32'h0014_1031 >> (8 * (w - 'h3F8))) & 32'hFF;
                if (w >= 'h3FC && w <= 'h3FF) return (32'hB105_F00D >> (8 * (w - 'h3FC))) & 32'hFF;
                return 32'd0;
            end
        endcase
    endfunction

    // behavioural model, advanced at every edge
    always @(posedge clk) begin
        if (rst) begin
            m_presc = 0; m_count = 0; m_match = 0; m_load = 0; m_mask = 0; m_raw = 0;
        end else begin
            bit wr, tk, ld, ev;
            int w;
            wr = psel && penable && pwrite && (paddr[1:0] == 2'b00);
            w  = int'(paddr >> 2);
            tk = (m_presc == DIV - 1);
            m_presc = tk ? 0 : m_presc + 1;
            ld = wr && (w == 2);
            ev = tk && !ld && ((m_count + 32'd1) == m_match);
            if (ld) begin m_count = pwdata; m_load = pwdata; end
            else if (tk) m_count = m_count + 32'd1;
            if (wr && w == 1) m_match = pwdata;
            if (wr && w == 4) m_mask = pwdata[0];
            if (ev) m_raw = 1'b1;
            else if (wr && w == 7 && pwdata[0]) m_raw = 1'b0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(irq == (m_raw & m_mask), "R8 irq", {31'd0, irq}, {31'd0, m_raw & m_mask});
            check(pready === 1'b1 && pslverr === 1'b0, "R12 handshake", {30'd0, pready, pslverr}, 32'h2);
            if (psel && penable && !pwrite)
                check(prdata == model_read(paddr), "MODEL read", prdata, model_read(paddr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge clk); #1;
        penable = 1;
        @(negedge clk);
        check(prdata == exp, tag, prdata, exp);
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    task automatic bus_read_model(input logic [11:0] a, input string tag);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge clk); #1;
        penable = 1;
        @(negedge clk);
        check(prdata == model_read(a), tag, prdata, model_read(a));
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    initial begin
        logic [31:0] pid = 32'h0014_1031;
        logic [31:0] cid = 32'hB105_F00D;
        idle(3);
        @(posedge clk); #1; rst = 0;

        // R1 reset state
        bus_read(12'h000, 32'd0, "R1 count");
        bus_read(12'h004, 32'd0, "R1 match");
        bus_read(12'h008, 32'd0, "R1 load");
        bus_read(12'h010, 32'd0, "R1 mask");
        bus_read(12'h014, 32'd0, "R1 raw");
        check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);

        // R9 control, R10 IDs, R11 unassigned
        bus_read(12'h00C, 32'd1, "R9 ctrl");
        for (int i = 0; i < 4; i++) begin
            bus_read(12'hFE0 + 12'(4 * i), (pid >> (8 * i)) & 32'hFF, "R10 periph id");
            bus_read(12'hFF0 + 12'(4 * i), (cid >> (8 * i)) & 32'hFF, "R10 cell id");
        end
        bus_read(12'h020, 32'd0, "R11 unassigned");
        bus_read(12'h01C, 32'd0, "R11 clear reads 0");
        bus_read(12'h005, 32'd0, "R11 misaligned");

        // R2 load
        bus_write(12'h008, 32'd100);
        bus_read(12'h008, 32'd100, "R2 load reg");
        bus_read_model(12'h000, "R2 count after load");

        // R3 counting and R11 write to read-only count
        idle(17);
        bus_read_model(12'h000, "R3 count advance");
        bus_write(12'h000, 32'hDEAD_0000);
        bus_write(12'hFE0, 32'hFFFF_FFFF);
        bus_write(12'h014, 32'h1);
        bus_read_model(12'h000, "R11 count unaffected");
        bus_read(12'hFE0, 32'h31, "R11 id unaffected");
        bus_read(12'h014, 32'd0, "R11 raw unaffected");

        // R6 mask writes only bit 0
        bus_write(12'h010, 32'hFFFF_FFFE);
        bus_read(12'h010, 32'd0, "R6 mask bit0 zero");
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_read(12'h010, 32'd1, "R6 mask bit0 one");
        bus_write(12'h010, 32'd0);

        // R4 match event, sticky
        bus_write(12'h008, 32'd10);
        bus_write(12'h004, 32'd12);
        idle(14);
        bus_read(12'h014, 32'd1, "R4 raw set");
        bus_read(12'h018, 32'd0, "R6 masked off");
        check(irq == 1'b0, "R8 irq masked", {31'd0, irq}, 32'd0);
        idle(12);
        bus_read(12'h014, 32'd1, "R4 raw sticky");
        bus_write(12'h010, 32'd1);
        bus_read(12'h018, 32'd1, "R6 masked on");
        check(irq == 1'b1, "R8 irq high", {31'd0, irq}, 32'd1);

        // R7 clear
        bus_write(12'h01C, 32'hFFFF_FFFE);
        bus_read(12'h014, 32'd1, "R7 clear bit0 zero keeps");
        bus_write(12'h01C, 32'd1);
        bus_read(12'h014, 32'd0, "R7 clear");
        check(irq == 1'b0, "R8 irq after clear", {31'd0, irq}, 32'd0);

        // R5 load into match value: no event
        bus_write(12'h004, 32'd50);
        bus_write(12'h008, 32'd50);
        idle(12);
        bus_read(12'h014, 32'd0, "R5 load equal");
        // R5 match written equal to count
        bus_write(12'h008, 32'd200);
        bus_write(12'h004, 32'd200);
        bus_read_model(12'h014, "R5 match equal model");
        idle(10);
        bus_read(12'h014, 32'd0, "R5 match equal no event");

        // R3 wrap, R4 event at zero
        bus_write(12'h004, 32'd0);
        bus_write(12'h008, 32'hFFFF_FFFE);
        idle(14);
        bus_read(12'h014, 32'd1, "R3 wrap event");
        bus_read_model(12'h000, "R3 wrapped count");
        check(irq == 1'b1, "R8 irq wrap", {31'd0, irq}, 32'd1);

        // repeated clears against running ticks
        for (int k = 0; k < 20; k++) begin
            bus_write(12'h004, m_count + 32'd1);
            bus_write(12'h01C, 32'd1);
            idle(k % 5);
        end
        bus_read_model(12'h014, "R7 clear vs event");

        idle(2);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule